// File: doc/BRIEF.md
# Multi-Line Receive Silo with Alarm

This block gathers received characters from up to eight serial lines into one shared first-in first-out silo. A processor drains the silo one entry at a time through a read-only receive word. Each word carries the character, the number of the line it came from, and flags for valid, framing error (break) and overrun. The bit-level deserialisers sit outside: each line delivers a one-cycle byte strobe or a break strobe.

Each line has a capture register. Bytes that arrive on several lines in the same cycle are held there and moved into the silo one per cycle, lowest line first. Software turns each line's reception on or off with a configuration write. The block drives a receive-done flag and a one-shot silo-alarm flag, and from these it forms a receive interrupt request. An enable bit picks which of the two flags drives the request.

Top module: `rx_silo`

## Requirements
- R1: A read that pops an entry returns a 16-bit word. Bit 15 is valid (1), bit 14 is overrun, bit 13 is framing error, bits 10:8 are the source line and bits 7:0 are the character. Bits 12 and 11 always read 0.
- R2: A break strobe on an enabled line is stored as an entry with valid and framing error set, character 0, and the line number filled in.
- R3: Entries come out in arrival order. Bytes strobed on several lines in the same cycle enter the silo in ascending line order.
- R4: A configuration write sets or clears one line's receive enable. Bits 2:0 select the line and bit 12 is the new enable. Strobes on a disabled line are ignored.
- R5: `rx_done` is high exactly when scan is enabled and the silo holds at least one entry.
- R6: While the alarm is armed, the silo count reaching ALARM_LEVEL (default 16) sets `silo_alarm` and disarms the alarm. It does not fire again until it is re-armed.
- R7: Every receive read clears `silo_alarm`. A read with scan enabled and the silo empty returns 0 and re-arms the alarm.
- R8: With scan disabled, a read returns 0 and removes nothing from the silo.
- R9: `rx_irq` is high when `rx_ie` is set and the selected flag is set. The selected flag is `silo_alarm` when `alarm_ie` is set, and `rx_done` otherwise.
- R10: When the silo is full and no read is in progress, a new character is dropped and the overrun bit of the most recently stored entry is set.
- R11: A clear pulse empties the silo and the capture registers, arms the alarm, clears `silo_alarm` and clears every line's receive enable.
- R12: After reset, `rbuf_data` is 0, all flags are low, the silo is empty and all lines are disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Clear pulse |
| scan_en | input | 1 | Scan enable |
| rx_ie | input | 1 | Receive interrupt enable |
| alarm_ie | input | 1 | Selects the alarm as the interrupt source |
| cfg_wr | input | 1 | Line configuration write strobe |
| cfg_word | input | 16 | Configuration word: bits 2:0 line, bit 12 enable |
| line_strobe | input | NUM_LINES | Per-line byte-received strobe |
| line_break | input | NUM_LINES | Per-line break-detected strobe |
| line_byte | input | 8*NUM_LINES | Per-line received byte |
| rbuf_rd | input | 1 | Receive word read strobe |
| rbuf_data | output | 16 | Result of the last receive read |
| rx_done | output | 1 | Receive done flag |
| silo_alarm | output | 1 | Silo alarm flag |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The bench builds the block with eight lines, a silo depth of 24 and an alarm level of 16. With these values a full silo and the overrun on its last entry take only a few dozen strobes to reach. Between the alarm level and full depth there is room to show that the alarm stays disarmed while the silo keeps filling, and that it fires again only after an empty read has re-armed it. The bench also checks same-cycle arrivals on three lines, a break entry, a disabled line, reads with scan off, and the effect of a clear.

// File: rtl/rx_silo_pkg.sv
// Shared types for the receive silo.
// Assumes at most eight lines, so the line number fits the 3-bit field.
package rx_silo_pkg;

    typedef struct packed {
        logic       ovr;
        logic       fe;
        logic [2:0] line;
        logic [7:0] chr;
    } silo_entry_t;

    localparam int CFG_EN_BIT = 12;

    // Build the 16-bit receive word for a popped entry (valid set).
    function automatic logic [15:0] to_word(silo_entry_t e);
        return {1'b1, e.ovr, e.fe, 2'b00, e.line, e.chr};
    endfunction

endpackage

// File: rtl/rx_line_capture.sv
// Per-line capture registers with receive enables and a lowest-line-first
// arbiter that hands one entry per cycle to the silo.
// Assumes a line strobes again only after its held byte has drained
// (at most NUM_LINES cycles); a later strobe overwrites a held byte.
module rx_line_capture
    import rx_silo_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   cfg_wr,
    input  logic [15:0]            cfg_word,
    input  logic [NUM_LINES-1:0]   line_strobe,
    input  logic [NUM_LINES-1:0]   line_break,
    input  logic [8*NUM_LINES-1:0] line_byte,
    output logic                   push,
    output silo_entry_t            push_entry
);
    localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    logic [NUM_LINES-1:0] rx_en;
    logic [NUM_LINES-1:0] pend;
    logic [NUM_LINES-1:0] grant;
    silo_entry_t          hold [NUM_LINES];

    // Lowest pending line wins.
    assign grant = pend & (~pend + NUM_LINES'(1));
    assign push  = |pend;

    // Select the granted entry.
    always_comb begin
        push_entry = '0;
        for (int i = 0; i < NUM_LINES; i++)
            if (grant[i]) push_entry = hold[i];
    end

    // Enables, capture and drain of the per-line registers.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            rx_en <= '0;
            pend  <= '0;
        end else begin
            if (cfg_wr && (int'(cfg_word[LINE_W-1:0]) < NUM_LINES))
                rx_en[cfg_word[LINE_W-1:0]] <= cfg_word[CFG_EN_BIT];
            for (int i = 0; i < NUM_LINES; i++) begin
                if (rx_en[i] && (line_strobe[i] || line_break[i])) begin
                    pend[i]      <= 1'b1;
                    hold[i].ovr  <= 1'b0;
                    hold[i].fe   <= line_break[i];
                    hold[i].line <= 3'(i);
                    hold[i].chr  <= line_break[i] ? 8'h00 : line_byte[8*i +: 8];
                end else if (grant[i]) begin
                    pend[i] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/rx_silo_fifo.sv
// Circular silo of DEPTH entries. Drops a push when full (unless a pop
// frees a slot in the same cycle) and marks overrun on the newest entry.
// Assumes pop is asserted only when count is non-zero.
module rx_silo_fifo
    import rx_silo_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  silo_entry_t      push_entry,
    input  logic             pop,
    output silo_entry_t      head,
    output logic [CNT_W-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    silo_entry_t      mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr, last_ptr;
    logic             accept, overflow;

    function automatic logic [PTR_W-1:0] step(logic [PTR_W-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + PTR_W'(1);
    endfunction

    assign accept   = push && ((count != CNT_W'(DEPTH)) || pop);
    assign overflow = push && !accept;
    assign last_ptr = (wr_ptr == '0) ? PTR_W'(DEPTH - 1) : wr_ptr - PTR_W'(1);
    assign head     = mem[rd_ptr];

    // Pointer, count and storage update.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (accept) begin
                mem[wr_ptr] <= push_entry;
                wr_ptr      <= step(wr_ptr);
            end
            if (overflow) mem[last_ptr].ovr <= 1'b1;
            if (pop) rd_ptr <= step(rd_ptr);
            count <= count + CNT_W'(accept) - CNT_W'(pop);
        end
    end
endmodule

// File: rtl/rx_status_ctl.sv
// Receive-done, one-shot silo alarm with arming, and interrupt selection.
// Assumes count is the registered silo occupancy.
module rx_status_ctl #(
    parameter int ALARM_LEVEL = 16,
    parameter int CNT_W       = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             scan_en,
    input  logic             rx_ie,
    input  logic             alarm_ie,
    input  logic             rd,
    input  logic [CNT_W-1:0] count,
    output logic             rx_done,
    output logic             silo_alarm,
    output logic             rx_irq
);
    logic armed;
    logic empty;

    assign empty   = (count == '0);
    assign rx_done = scan_en && !empty;
    assign rx_irq  = rx_ie && (alarm_ie ? silo_alarm : rx_done);

    // Alarm arming, firing and clearing.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            armed      <= 1'b1;
            silo_alarm <= 1'b0;
        end else begin
            if (rd) silo_alarm <= 1'b0;
            if (rd && scan_en && empty) armed <= 1'b1;
            if (armed && scan_en && (count >= CNT_W'(ALARM_LEVEL))) begin
                silo_alarm <= 1'b1;
                armed      <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rx_silo.sv
// Top of the multi-line receive silo: capture, silo, status and the
// receive word register.
// Assumes NUM_LINES <= 8 and a single-cycle rbuf_rd strobe per read.
module rx_silo
    import rx_silo_pkg::*;
#(
    parameter int NUM_LINES   = 8,
    parameter int DEPTH       = 64,
    parameter int ALARM_LEVEL = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   scan_en,
    input  logic                   rx_ie,
    input  logic                   alarm_ie,
    input  logic                   cfg_wr,
    input  logic [15:0]            cfg_word,
    input  logic [NUM_LINES-1:0]   line_strobe,
    input  logic [NUM_LINES-1:0]   line_break,
    input  logic [8*NUM_LINES-1:0] line_byte,
    input  logic                   rbuf_rd,
    output logic [15:0]            rbuf_data,
    output logic                   rx_done,
    output logic                   silo_alarm,
    output logic                   rx_irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             push, pop;
    silo_entry_t      push_entry, head;
    logic [CNT_W-1:0] silo_count;

    assign pop = rbuf_rd && scan_en && (silo_count != '0) && !clear;

    rx_line_capture #(.NUM_LINES(NUM_LINES)) u_capture (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .cfg_wr(cfg_wr), .cfg_word(cfg_word),
        .line_strobe(line_strobe), .line_break(line_break), .line_byte(line_byte),
        .push(push), .push_entry(push_entry)
    );

    rx_silo_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .push(push), .push_entry(push_entry), .pop(pop),
        .head(head), .count(silo_count)
    );

    rx_status_ctl #(.ALARM_LEVEL(ALARM_LEVEL), .CNT_W(CNT_W)) u_status (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .scan_en(scan_en), .rx_ie(rx_ie), .alarm_ie(alarm_ie),
        .rd(rbuf_rd), .count(silo_count),
        .rx_done(rx_done), .silo_alarm(silo_alarm), .rx_irq(rx_irq)
    );

    // Receive word: popped entry, or zero for empty or scan-off reads.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) rbuf_data <= '0;
        else if (rbuf_rd)    rbuf_data <= pop ? to_word(head) : 16'h0000;
    end
endmodule

// File: rtl/rx_silo_chk.sv
// Checker for rx_silo, attached by bind. Observes ports and silo count.
module rx_silo_chk #(
    parameter int DEPTH = 64,
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clear,
    input logic             scan_en,
    input logic             rx_ie,
    input logic             alarm_ie,
    input logic             rbuf_rd,
    input logic [15:0]      rbuf_data,
    input logic             rx_done,
    input logic             silo_alarm,
    input logic             rx_irq,
    input logic [CNT_W-1:0] silo_count
);
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rbuf_data[12:11] == 2'b00);

    a_r1_valid_on_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (rbuf_rd && scan_en && silo_count != '0 && !clear) |=> rbuf_data[15]);

    a_r5_done_needs_scan: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |-> !rx_done);

    a_r7_read_clears_alarm: assert property (@(posedge clk) disable iff (!rst_n)
        (rbuf_rd && silo_alarm) |=> !silo_alarm);

    a_r7_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rbuf_rd && scan_en && silo_count == '0) |=> rbuf_data == 16'h0000);

    a_r8_scan_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rbuf_rd && !scan_en) |=> (rbuf_data == 16'h0000 && $stable(silo_count)));

    a_r9_alarm_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_ie && !silo_alarm) |-> !rx_irq);

    a_r9_ie_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ie |-> !rx_irq);

    a_r10_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        int'(silo_count) <= DEPTH);

    a_r11_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (silo_count == '0 && !silo_alarm && !rx_done));
endmodule

bind rx_silo rx_silo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .clear(clear), .scan_en(scan_en),
    .rx_ie(rx_ie), .alarm_ie(alarm_ie), .rbuf_rd(rbuf_rd),
    .rbuf_data(rbuf_data), .rx_done(rx_done), .silo_alarm(silo_alarm),
    .rx_irq(rx_irq), .silo_count(silo_count)
);

// File: tb/tb_rx_silo.sv
// Scoreboard bench: the driver tasks push expected words, the read
// monitor pops them and compares against rbuf_data.
module tb_rx_silo;
    localparam int NL = 8;
    localparam int DP = 24;
    localparam int AL = 16;

    logic            clk = 0;
    logic            rst_n = 0;
    logic            clear = 0, scan_en = 0, rx_ie = 0, alarm_ie = 0;
    logic            cfg_wr = 0;
    logic [15:0]     cfg_word = 0;
    logic [NL-1:0]   line_strobe = 0, line_break = 0;
    logic [8*NL-1:0] line_byte = 0;
    logic            rbuf_rd = 0;
    logic [15:0]     rbuf_data;
    logic            rx_done, silo_alarm, rx_irq;

    int errors = 0, checks = 0;
    logic [15:0] expq [$];
    bit          en_model [NL];

    always #5 clk = ~clk;

    rx_silo #(.NUM_LINES(NL), .DEPTH(DP), .ALARM_LEVEL(AL)) dut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .scan_en(scan_en),
        .rx_ie(rx_ie), .alarm_ie(alarm_ie), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
        .line_strobe(line_strobe), .line_break(line_break), .line_byte(line_byte),
        .rbuf_rd(rbuf_rd), .rbuf_data(rbuf_data), .rx_done(rx_done),
        .silo_alarm(silo_alarm), .rx_irq(rx_irq)
    );

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Expected model of a push: overrun marks the newest entry when full (R10).
    task automatic push_exp(logic [15:0] w);
        if (expq.size() == DP) expq[expq.size()-1] = expq[expq.size()-1] | 16'h4000;
        else expq.push_back(w);
    endtask

    task automatic cfg(int ln, bit en);
        @(negedge clk);
        cfg_wr = 1; cfg_word = 16'(ln) | (en ? 16'h1000 : 16'h0000);
        @(negedge clk);
        cfg_wr = 0;
        en_model[ln] = en;
    endtask

    task automatic send(int ln, logic [7:0] b, bit brk);
        @(negedge clk);
        line_strobe[ln] = !brk; line_break[ln] = brk; line_byte[8*ln +: 8] = b;
        @(negedge clk);
        line_strobe = '0; line_break = '0;
        repeat (2) @(negedge clk);
        if (en_model[ln])
            push_exp({1'b1, 1'b0, brk, 2'b00, 3'(ln), brk ? 8'h00 : b});
    endtask

    // Same-cycle strobes on several lines; expected in ascending line order.
    task automatic send_multi(logic [NL-1:0] mask, logic [7:0] base);
        @(negedge clk);
        for (int i = 0; i < NL; i++)
            if (mask[i]) begin line_strobe[i] = 1; line_byte[8*i +: 8] = base + 8'(i); end
        @(negedge clk);
        line_strobe = '0;
        repeat (NL + 1) @(negedge clk);
        for (int i = 0; i < NL; i++)
            if (mask[i] && en_model[i]) push_exp({5'b10000, 3'(i), base + 8'(i)});
    endtask

    // Read monitor: pops the scoreboard and compares.
    task automatic read_check(string tag);
        logic [15:0] exp;
        @(negedge clk);
        rbuf_rd = 1;
        @(negedge clk);
        rbuf_rd = 0;
        exp = (scan_en && expq.size() > 0) ? expq.pop_front() : 16'h0000;
        check(tag, rbuf_data, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R12 rbuf after reset", rbuf_data, 16'h0000);
        check("R12 flags after reset", {13'b0, rx_done, silo_alarm, rx_irq}, 16'h0000);

        scan_en = 1; rx_ie = 1; alarm_ie = 0;
        send(5, 8'h55, 0);                       // R4 line 5 still disabled
        check("R4 disabled line ignored", {15'b0, rx_done}, 16'h0000);
        read_check("R4 disabled line read");
        for (int i = 0; i < NL; i++) cfg(i, 1);

        send(3, 8'h41, 0);
        check("R5 done with entry", {15'b0, rx_done}, 16'h0001);
        check("R9 irq from done", {15'b0, rx_irq}, 16'h0001);
        read_check("R1 word format line 3");
        check("R5 done clear when empty", {15'b0, rx_done}, 16'h0000);

        send_multi(8'b0101_0010, 8'h60);         // R3 lines 1,4,6 together
        read_check("R3 order first");
        read_check("R3 order second");
        read_check("R3 order third");

        send(2, 8'h77, 1);
        read_check("R2 break entry");
        cfg(2, 0);
        send(2, 8'h12, 0);
        check("R4 line 2 disabled again", {15'b0, rx_done}, 16'h0000);

        alarm_ie = 1;
        for (int k = 0; k < AL - 1; k++) send(k % 2, 8'(8'h80 + k), 0);
        check("R9 alarm mode no irq", {14'b0, silo_alarm, rx_irq}, 16'h0000);
        send(3, 8'hA0, 0);
        check("R6 alarm at level", {14'b0, silo_alarm, rx_irq}, 16'h0003);
        read_check("R1 oldest entry under alarm");
        check("R7 read clears alarm", {15'b0, silo_alarm}, 16'h0000);
        send(4, 8'hB0, 0);
        check("R6 no refire while disarmed", {15'b0, silo_alarm}, 16'h0000);
        for (int k = 0; k < 10; k++) send(6, 8'(8'hC0 + k), 0);   // fill and overrun
        check("R10 queue model full", 16'(expq.size()), 16'(DP));

        scan_en = 0;
        @(negedge clk);
        check("R5 done off without scan", {15'b0, rx_done}, 16'h0000);
        read_check("R8 scan off read zero");
        scan_en = 1;
        for (int k = 0; k < DP; k++) read_check(k == DP - 1 ? "R10 overrun on last" : "R3 drain");
        read_check("R7 empty read zero");
        for (int k = 0; k < AL; k++) send(1, 8'(k), 0);
        check("R7 rearmed alarm fires", {15'b0, silo_alarm}, 16'h0001);

        @(negedge clk);
        clear = 1;
        @(negedge clk);
        clear = 0;
        expq.delete();
        for (int i = 0; i < NL; i++) en_model[i] = 0;
        check("R11 flags after clear", {13'b0, rx_done, silo_alarm, rx_irq}, 16'h0000);
        send(0, 8'h99, 0);
        check("R11 enables cleared", {15'b0, rx_done}, 16'h0000);
        read_check("R11 silo empty after clear");
        report();
    end
endmodule